// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Address Stall

This block is a small RAM with two ports. Each port writes through per-byte enables on the falling edge of the clock and reads asynchronously. A 16-bit word is split into two 8-bit lanes. A write changes only the lanes whose enable bit is set, and only while that port's write enable is high.

Each port holds its address in a register that loads on the rising clock edge. The port's stall input freezes that register, so a port can keep working on one location while its address bus moves on. The read data is the word at the registered address. It changes as soon as that register changes, and again as soon as a falling-edge write alters the stored word.

A build parameter selects packed operation. In that mode the two ports act as two separate single-port RAMs, each half the depth of the array. The most significant physical address bit is tied to the port: port A always works in the lower half and port B always works in the upper half. When both ports write the same word on one edge, port A wins on the lanes it enables.

Top module: `bytelane_ram`

## Requirements
- R1: A write lands on the falling clock edge. Between a rising edge and the following falling edge, the stored contents still hold their values from before that write.
- R2: Read data is combinational from the registered address and the stored word. After the rising edge that captures an address, rdata shows that word. After a falling-edge write, rdata shows the new contents without waiting for another rising edge.
- R3: Byte-enable bit 1 guards bits 15:8 and bit 0 guards bits 7:0. With enables 10, writing ABCD over FFFF leaves ABFF.
- R4: With enables 01, writing ABCD over FFFF leaves FFCD. With enables 11, the whole word ABCD is stored.
- R5: While a port's write enable is low, that port changes no lane, whatever its byte enables and data are.
- R6: On a rising edge, a port's address register loads the address input when the port's stall input is 0. It keeps its old value when stall is 1. Reads and writes use the registered value.
- R7: The stall inputs of the two ports act independently. Stalling one port does not freeze the other port's address register.
- R8: While rst_n is low, both address registers clear to 0 on the rising edge and every word becomes FFFF on the falling edge.
- R9: If both ports write the same physical word on one falling edge, port A's lanes win wherever port A's byte enable is set. Lanes that only port B enables take port B's data.
- R10: With PACKED=1, the physical address MSB is 0 for port A and 1 for port B, whatever the address inputs carry in their MSB. This gives two independent half-depth RAMs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: rising edge loads the address registers, falling edge writes |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | ADDR_W | Port A address |
| a_stall | input | 1 | Port A address-register freeze |
| a_we | input | 1 | Port A write enable |
| a_be | input | DATA_W/8 | Port A byte enables |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A asynchronous read data |
| b_addr | input | ADDR_W | Port B address |
| b_stall | input | 1 | Port B address-register freeze |
| b_we | input | 1 | Port B write enable |
| b_be | input | DATA_W/8 | Port B byte enables |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B asynchronous read data |

## Verification
Two cases are the hardest to reach from the ports: a stalled port writing to an address other than the one on its bus, and a same-edge collision in which the two ports use different lane masks. The stimulus first loads an address with stall low. It then raises stall, changes the address input and writes, so the write lands at the frozen location. Next it drops stall and reads both locations back. The same stimulus drives a plain instance and a packed instance side by side. A collision in the plain instance therefore becomes two separate writes in the packed one, and the MSB override is exercised in both directions.

// File: rtl/bytelane_ram.sv
module bytelane_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter bit PACKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_stall,
  input  logic              a_we,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_stall,
  input  logic              b_we,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP_BIT = ADDR_W'(1) << (ADDR_W - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a_addr_q, b_addr_q, a_phys, b_phys;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_addr_q <= '0;
      b_addr_q <= '0;
    end else begin
      if (!a_stall) a_addr_q <= a_addr;
      if (!b_stall) b_addr_q <= b_addr;
    end
  end

  assign a_phys = PACKED ? (a_addr_q & ~TOP_BIT) : a_addr_q;
  assign b_phys = PACKED ? (b_addr_q | TOP_BIT) : b_addr_q;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (b_we && b_be[l]) mem[b_phys][l*8 +: 8] <= b_wdata[l*8 +: 8];
      for (int l = 0; l < LANES; l++)
        if (a_we && a_be[l]) mem[a_phys][l*8 +: 8] <= a_wdata[l*8 +: 8];
    end
  end

  assign a_rdata = mem[a_phys];
  assign b_rdata = mem[b_phys];

  // R6
  a_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_stall |=> $stable(a_addr_q));
  // R6
  a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_stall |=> a_addr_q == $past(a_addr));
  // R7
  b_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_stall |=> $stable(b_addr_q));
  // R7
  b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_stall |=> b_addr_q == $past(b_addr));
  // R8
  reset_fill_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (a_rdata == '1 && b_rdata == '1));
endmodule

// File: tb/bytelane_ram_tb_top.sv
module bytelane_ram_tb_top;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_stall = 1'b0, b_stall = 1'b0, a_we = 1'b0, b_we = 1'b0;
  logic [1:0] a_be = '0, b_be = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] ua_rd, ub_rd, pa_rd, pb_rd;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] mu [DEP];
  logic [DW-1:0] mp [DEP];
  int ma = 0, mb = 0;

  always #4 clk = ~clk;

  bytelane_ram #(.DATA_W(DW), .ADDR_W(AW), .PACKED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_stall(a_stall), .a_we(a_we), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(ua_rd),
    .b_addr(b_addr), .b_stall(b_stall), .b_we(b_we), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(ub_rd));

  bytelane_ram #(.DATA_W(DW), .ADDR_W(AW), .PACKED(1'b1)) dut_p (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_stall(a_stall), .a_we(a_we), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(pa_rd),
    .b_addr(b_addr), .b_stall(b_stall), .b_we(b_we), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(pb_rd));

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h at %0t", what, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(ua_rd, mu[ma], {tag, " plain A"});
    chk(ub_rd, mu[mb], {tag, " plain B"});
    chk(pa_rd, mp[ma % (DEP/2)], {tag, " packed A"});
    chk(pb_rd, mp[(mb % (DEP/2)) + DEP/2], {tag, " packed B"});
  endtask

  task automatic lane_write(ref logic [DW-1:0] m [DEP], input int idx,
                            input logic [1:0] be, input logic [DW-1:0] d);
    if (be[0]) m[idx][7:0]  = d[7:0];
    if (be[1]) m[idx][15:8] = d[15:8];
  endtask

  task automatic step(input int aa, input bit as_, input bit awe, input logic [1:0] abe,
                      input logic [DW-1:0] awd,
                      input int ba, input bit bs_, input bit bwe, input logic [1:0] bbe,
                      input logic [DW-1:0] bwd, input string tag);
    a_addr = AW'(aa); a_stall = as_; a_we = awe; a_be = abe; a_wdata = awd;
    b_addr = AW'(ba); b_stall = bs_; b_we = bwe; b_be = bbe; b_wdata = bwd;
    @(posedge clk);
    if (!rst_n) begin ma = 0; mb = 0; end
    else begin
      if (!as_) ma = aa;
      if (!bs_) mb = ba;
    end
    #1 compare_all({"R1/R2 pre-write ", tag});
    @(negedge clk);
    if (!rst_n) begin
      for (int w = 0; w < DEP; w++) begin mu[w] = '1; mp[w] = '1; end
    end else begin
      if (bwe) begin
        lane_write(mu, mb, bbe, bwd);
        lane_write(mp, (mb % (DEP/2)) + DEP/2, bbe, bwd);
      end
      if (awe) begin
        lane_write(mu, ma, abe, awd);
        lane_write(mp, ma % (DEP/2), abe, awd);
      end
    end
    #2 compare_all(tag);
  endtask

  task automatic idle(input int aa, input int ba, input string tag);
    step(aa, 0, 0, 2'b00, '0, ba, 0, 0, 2'b00, '0, tag);
  endtask

  initial begin
    for (int w = 0; w < DEP; w++) begin mu[w] = 'x; mp[w] = 'x; end
    for (int i = 0; i < 3; i++) idle(0, 0, "R8 reset");
    rst_n = 1'b1;
    idle(0, 0, "R8 after reset");
    idle(9, 21, "R8 other words FFFF");

    step(3, 0, 1, 2'b10, 16'hABCD, 0, 0, 0, 2'b00, '0, "R3 upper lane");
    idle(3, 3, "R3 readback ABFF");
    step(4, 0, 1, 2'b01, 16'hABCD, 0, 0, 0, 2'b00, '0, "R4 lower lane");
    step(5, 0, 1, 2'b11, 16'hABCD, 4, 0, 0, 2'b00, '0, "R4 full word");
    idle(5, 4, "R4 readback");

    step(6, 0, 0, 2'b11, 16'h1234, 6, 0, 0, 2'b11, 16'h5678, "R5 we low");
    idle(6, 6, "R5 unchanged");

    idle(3, 0, "R6 load addr 3");
    step(9, 1, 1, 2'b11, 16'h5A5A, 0, 0, 0, 2'b00, '0, "R6 stalled write");
    idle(9, 3, "R6 addr 9 untouched");
    idle(3, 9, "R6 held addr got data");

    step(12, 1, 0, 2'b00, '0, 4, 0, 0, 2'b00, '0, "R7 A stalled B moves");
    step(13, 1, 0, 2'b00, '0, 5, 0, 0, 2'b00, '0, "R7 B moves again");
    step(14, 0, 0, 2'b00, '0, 5, 1, 0, 2'b00, '0, "R7 B stalled A moves");
    idle(14, 20, "R7 release");

    step(7, 0, 1, 2'b11, 16'h1111, 7, 0, 1, 2'b11, 16'h2222, "R9 full collision");
    idle(7, 7, "R9 port A wins");
    step(8, 0, 1, 2'b10, 16'h3300, 8, 0, 1, 2'b11, 16'h0044, "R9 lane collision");
    idle(8, 8, "R9 mixed lanes");

    step(18, 0, 1, 2'b11, 16'h7777, 2, 0, 0, 2'b00, '0, "R10 A with MSB set");
    idle(2, 2, "R10 halves separate");
    step(0, 0, 0, 2'b00, '0, 2, 0, 1, 2'b11, 16'h8888, "R10 B write");
    idle(2, 18, "R10 readback");
    idle(18, 2, "R10 MSB ignored");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule